// File: doc/BRIEF.md
# Baud-Rate-Timed Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A prescaler picks one of four count sources (the system clock divided by 1, 2, 8 or 32), and a reload counter divides that source by a programmable value to give a stream of overflow pulses. Every serial bit lasts sixteen overflows. The transmitter moves a written word into a frame and starts that frame only on the second overflow after the write. The receiver oversamples the line with the same overflows, checks the start bit at its middle, and samples every later bit at its centre.

The receive side has a one-word buffer. The ready-to-send output reports whether that buffer still holds unread data, and it returns to ready as soon as the word is read. It does not return when reception ends. The receiver raises an overrun when a new frame reaches the bit just before its last stop bit while the earlier word is still unread, and it keeps that earlier word. Clear-to-send gating of the transmitter and the ready-to-send output each have their own enable, so either one can be used alone.

Top module: `uart_brg_xcvr`

## Requirements
- R1: The overflow period is (brg_div_i+1)·P clocks, with P = 1, 2, 8 or 32 for clk_sel_i = 0, 1, 2 or 3. Every transmitted bit, including the start bit, lasts exactly 16 overflow periods.
- R2: After a write on tx_we_i, tx_o goes low in the clock after the second overflow that follows the write edge. A write while tx_busy_o is high is ignored.
- R3: A frame is made of a low start bit, data LSB first, an optional parity bit and 1 or 2 high stop bits. The data is 7, 8 or 9 bits for data_len_i = 0, 1 or 2. The parity bit is even when parity_odd_i = 0 and odd when it is 1. The line is high whenever tx_busy_o is low.
- R4: While cts_en_i and cts_i are both high, no frame starts. Once cts_i falls, the frame starts on the next overflow, provided two overflows have already passed since the write. A frame that has already started completes. When cts_en_i is low, cts_i has no effect.
- R5: The receiver checks the start bit eight overflows after it sees the line low, and a start pulse that is shorter than this is dropped. It then samples each bit 16 overflows apart. A word received with fewer than 9 data bits appears zero-extended on rx_data_o with rx_valid_o high. A pulse on rx_read_i clears rx_valid_o.
- R6: With rts_en_i high, rts_o is high while rx_valid_o is high and goes low on the clock edge that takes the read. With rts_en_i low, rts_o stays low.
- R7: overrun_o sets when the bit just before the last stop bit is sampled and the buffer is still unread. In that case the earlier word stays in the buffer. If the buffer is read before that bit, no overrun is flagged and the new word is stored.
- R8: frame_err_o sets when a stop bit is sampled low. The word is still stored. frame_err_o and overrun_o both stay set until rx_en_i is low, which clears them.
- R9: While rx_en_i is low, the receiver ignores the line and stores no word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clk_sel_i | input | 2 | Prescaler select: divide by 1, 2, 8 or 32 |
| brg_div_i | input | DIV_W | Reload value of the baud counter |
| data_len_i | input | 2 | Data length: 0 = 7, 1 = 8, 2 = 9 bits |
| parity_en_i | input | 1 | Adds a parity bit to the frame |
| parity_odd_i | input | 1 | Selects odd parity instead of even |
| stop2_i | input | 1 | Selects two stop bits |
| tx_data_i | input | 9 | Word to transmit |
| tx_we_i | input | 1 | Write strobe for tx_data_i |
| tx_o | output | 1 | Serial output, idles high |
| tx_busy_o | output | 1 | A word is waiting or a frame is being sent |
| cts_en_i | input | 1 | Enables clear-to-send gating |
| cts_i | input | 1 | Clear-to-send; high holds off a new frame |
| rx_en_i | input | 1 | Receiver enable; low clears the error flags |
| rx_i | input | 1 | Serial input |
| rx_read_i | input | 1 | Reads the receive buffer |
| rx_data_o | output | 9 | Received word |
| rx_valid_o | output | 1 | Receive buffer holds unread data |
| rts_en_i | input | 1 | Enables the ready-to-send output |
| rts_o | output | 1 | High = not ready; low = ready |
| overrun_o | output | 1 | Sticky overrun flag |
| frame_err_o | output | 1 | Sticky framing-error flag |

## Verification
The timing sweep covers every prescaler choice with two reload values. It sends a word whose first data bit is high, so the edge that ends the start bit shows whether each bit lasts sixteen overflows and whether the frame began on the second overflow or on the first. A format sweep covers all data lengths, parity settings and stop-bit counts over loopback. Each frame is checked bit by bit, so it tells LSB-first order, the parity sense and the stop-bit count apart. Further cases cover back-to-back frames with and without a read in the middle of the second frame, CTS held high before a frame and raised during a frame, hand-made frames with a low stop bit or a runt start pulse, and a disabled receiver. Together these tell the overrun bit position, read-driven RTS and the independence of CTS and RTS from the alternatives.

// File: rtl/uart_brg_pkg.sv
package uart_brg_pkg;
  localparam int MAX_DATA = 9;
  localparam int FRAME_W  = 13;
  localparam int OVS      = 16;
  localparam int CNT_W    = $clog2(OVS);
  localparam int PRE_W    = 5;

  typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_state_e;

  function automatic logic [3:0] data_bits(input logic [1:0] len);
    case (len)
      2'd0:    return 4'd7;
      2'd2:    return 4'd9;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/uart_brg_gen.sv
module uart_brg_gen
  import uart_brg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [1:0]       clk_sel_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             ovf_o
);
  logic [PRE_W-1:0] pre_q, mask;
  logic [DIV_W-1:0] brg_q;
  logic             src_tick;

  always_comb begin
    case (clk_sel_i)
      2'd0:    mask = PRE_W'(0);
      2'd1:    mask = PRE_W'(1);
      2'd2:    mask = PRE_W'(7);
      default: mask = PRE_W'(31);
    endcase
  end

  assign src_tick = (pre_q & mask) == mask;
  assign ovf_o    = src_tick && (brg_q == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
      brg_q <= '0;
    end else begin
      pre_q <= pre_q + 1'b1;
      if (src_tick) brg_q <= (brg_q == '0) ? div_i : brg_q - 1'b1;
    end
  end
endmodule

// File: rtl/uart_brg_tx.sv
module uart_brg_tx
  import uart_brg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ovf_i,
  input  logic [3:0]          nbits_i,
  input  logic                par_en_i,
  input  logic                par_odd_i,
  input  logic                stop2_i,
  input  logic [MAX_DATA-1:0] data_i,
  input  logic                we_i,
  input  logic                hold_i,
  output logic                tx_o,
  output logic                busy_o
);
  logic [MAX_DATA-1:0] buf_q, dmask;
  logic [FRAME_W-1:0]  sh_q, frame;
  logic [3:0]          left_q, n_total;
  logic [CNT_W-1:0]    sub_q;
  logic                full_q, wait_q, act_q, tx_q, par;

  assign dmask   = ~({MAX_DATA{1'b1}} << nbits_i);
  assign par     = par_odd_i ^ (^(buf_q & dmask));
  assign n_total = 4'd2 + nbits_i + {3'b0, par_en_i} + {3'b0, stop2_i};

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < MAX_DATA; i++)
      if (i < int'(nbits_i)) frame[1+i] = buf_q[i];
    if (par_en_i) frame[int'(nbits_i)+1] = par;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      buf_q  <= '0;
      sh_q   <= '1;
      left_q <= '0;
      sub_q  <= '0;
      full_q <= 1'b0;
      wait_q <= 1'b0;
      act_q  <= 1'b0;
      tx_q   <= 1'b1;
    end else begin
      if (we_i && !busy_o) begin
        buf_q  <= data_i;
        full_q <= 1'b1;
        wait_q <= 1'b0;
      end else if (full_q && ovf_i) begin
        // first overflow only arms; start needs the second one
        if (!wait_q) wait_q <= 1'b1;
        else if (!hold_i) begin
          sh_q   <= frame;
          tx_q   <= 1'b0;
          left_q <= n_total - 4'd1;
          sub_q  <= '0;
          act_q  <= 1'b1;
          full_q <= 1'b0;
        end
      end
      if (act_q && ovf_i) begin
        sub_q <= sub_q + 1'b1;
        if (sub_q == CNT_W'(OVS-1)) begin
          if (left_q == '0) begin
            act_q <= 1'b0;
            tx_q  <= 1'b1;
          end else begin
            sh_q   <= sh_q >> 1;
            tx_q   <= sh_q[1];
            left_q <= left_q - 4'd1;
          end
        end
      end
    end
  end

  assign tx_o   = tx_q;
  assign busy_o = full_q | act_q;
endmodule

// File: rtl/uart_brg_rx.sv
module uart_brg_rx
  import uart_brg_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                ovf_i,
  input  logic                rx_i,
  input  logic                en_i,
  input  logic [3:0]          nbits_i,
  input  logic                par_en_i,
  input  logic                stop2_i,
  input  logic                read_i,
  output logic [MAX_DATA-1:0] data_o,
  output logic                full_o,
  output logic                ovr_o,
  output logic                ferr_o
);
  rx_state_e           st_q;
  logic [1:0]          sync_q;
  logic [3:0]          idx_q, last;
  logic [CNT_W-1:0]    cnt_q;
  logic [MAX_DATA-1:0] sh_q, data_q;
  logic                full_q, ovr_q, ferr_q, ferr_cur_q, rxs;

  assign rxs  = sync_q[1];
  assign last = nbits_i + {3'b0, par_en_i} + {3'b0, stop2_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= RX_IDLE;
      sync_q     <= 2'b11;
      idx_q      <= '0;
      cnt_q      <= '0;
      sh_q       <= '0;
      data_q     <= '0;
      full_q     <= 1'b0;
      ovr_q      <= 1'b0;
      ferr_q     <= 1'b0;
      ferr_cur_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], rx_i};
      if (read_i) full_q <= 1'b0;
      if (!en_i) begin
        st_q   <= RX_IDLE;
        ovr_q  <= 1'b0;
        ferr_q <= 1'b0;
      end else if (ovf_i) begin
        case (st_q)
          RX_IDLE: if (!rxs) begin
            st_q  <= RX_START;
            cnt_q <= '0;
          end
          RX_START: begin
            if (cnt_q == CNT_W'(OVS/2-1)) begin
              if (!rxs) begin
                st_q       <= RX_BITS;
                cnt_q      <= '0;
                idx_q      <= '0;
                sh_q       <= '0;
                ferr_cur_q <= 1'b0;
              end else st_q <= RX_IDLE;
            end else cnt_q <= cnt_q + 1'b1;
          end
          default: begin
            if (cnt_q == CNT_W'(OVS-1)) begin
              cnt_q <= '0;
              idx_q <= idx_q + 4'd1;
              if (idx_q < nbits_i) sh_q[idx_q] <= rxs;
              if (idx_q >= nbits_i + {3'b0, par_en_i} && !rxs) ferr_cur_q <= 1'b1;
              // overrun decided one bit ahead of the last stop bit
              if (idx_q == last - 4'd1 && full_q && !read_i) ovr_q <= 1'b1;
              if (idx_q == last) begin
                st_q <= RX_IDLE;
                if (ferr_cur_q || !rxs) ferr_q <= 1'b1;
                if (!full_q || read_i) begin
                  data_q <= sh_q;
                  full_q <= 1'b1;
                end
              end
            end else cnt_q <= cnt_q + 1'b1;
          end
        endcase
      end
    end
  end

  assign data_o = data_q;
  assign full_o = full_q;
  assign ovr_o  = ovr_q;
  assign ferr_o = ferr_q;
endmodule

// File: rtl/uart_brg_xcvr.sv
module uart_brg_xcvr
  import uart_brg_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [1:0]          clk_sel_i,
  input  logic [DIV_W-1:0]    brg_div_i,
  input  logic [1:0]          data_len_i,
  input  logic                parity_en_i,
  input  logic                parity_odd_i,
  input  logic                stop2_i,
  input  logic [MAX_DATA-1:0] tx_data_i,
  input  logic                tx_we_i,
  output logic                tx_o,
  output logic                tx_busy_o,
  input  logic                cts_en_i,
  input  logic                cts_i,
  input  logic                rx_en_i,
  input  logic                rx_i,
  input  logic                rx_read_i,
  output logic [MAX_DATA-1:0] rx_data_o,
  output logic                rx_valid_o,
  input  logic                rts_en_i,
  output logic                rts_o,
  output logic                overrun_o,
  output logic                frame_err_o
);
  logic       ovf;
  logic [3:0] nbits;

  assign nbits = data_bits(data_len_i);

  uart_brg_gen #(.DIV_W(DIV_W)) brg_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clk_sel_i (clk_sel_i),
    .div_i     (brg_div_i),
    .ovf_o     (ovf)
  );

  uart_brg_tx tx_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ovf_i     (ovf),
    .nbits_i   (nbits),
    .par_en_i  (parity_en_i),
    .par_odd_i (parity_odd_i),
    .stop2_i   (stop2_i),
    .data_i    (tx_data_i),
    .we_i      (tx_we_i),
    .hold_i    (cts_en_i & cts_i),
    .tx_o      (tx_o),
    .busy_o    (tx_busy_o)
  );

  uart_brg_rx rx_i_u (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ovf_i    (ovf),
    .rx_i     (rx_i),
    .en_i     (rx_en_i),
    .nbits_i  (nbits),
    .par_en_i (parity_en_i),
    .stop2_i  (stop2_i),
    .read_i   (rx_read_i),
    .data_o   (rx_data_o),
    .full_o   (rx_valid_o),
    .ovr_o    (overrun_o),
    .ferr_o   (frame_err_o)
  );

  assign rts_o = rts_en_i & rx_valid_o;
endmodule

// File: rtl/uart_brg_xcvr_chk.sv
module uart_brg_xcvr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tx_o,
  input logic       tx_busy_o,
  input logic       rx_en_i,
  input logic       rx_read_i,
  input logic [8:0] rx_data_o,
  input logic       rx_valid_o,
  input logic       rts_en_i,
  input logic       rts_o,
  input logic       overrun_o,
  input logic       frame_err_o
);
  assert_idle_line_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_busy_o |-> tx_o);

  assert_no_early_start_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(tx_busy_o) |=> tx_o);

  assert_rts_off_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rts_en_i |-> !rts_o);

  assert_buf_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o && !rx_read_i |=> rx_valid_o && $stable(rx_data_o));

  assert_ovr_needs_full_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> $past(rx_valid_o));

  assert_rx_off_clears_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_en_i |=> !overrun_o && !frame_err_o);
endmodule

bind uart_brg_xcvr uart_brg_xcvr_chk chk_i (.*);

// File: tb/uart_brg_xcvr_tb_top.sv
`timescale 1ns/1ps
module uart_brg_xcvr_tb_top;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic [1:0] clk_sel = '0, data_len = 2'd1;
  logic [7:0] brg_div = '0;
  logic       par_en = 0, par_odd = 0, stop2 = 0;
  logic [8:0] tx_data = '0;
  logic       tx_we = 0, cts_en = 0, cts = 0, rx_en = 1, rx_read = 0, rts_en = 1;
  logic       loop_en = 1, man_rx = 1, rx_line;
  logic       tx, tx_busy, rx_valid, rts, ovr, ferr;
  logic [8:0] rx_data;

  int n_chk = 0, n_bad = 0, cyc;
  int g_p = 1, g_d = 0, g_t = 1, g_start = 0, g_nd = 8;
  bit g_pe = 0, g_po = 0, g_s2 = 0;

  always #2 clk = ~clk;
  assign rx_line = loop_en ? tx : man_rx;

  uart_brg_xcvr dut_i (
    .clk_i(clk), .rst_ni(rst_n), .clk_sel_i(clk_sel), .brg_div_i(brg_div),
    .data_len_i(data_len), .parity_en_i(par_en), .parity_odd_i(par_odd), .stop2_i(stop2),
    .tx_data_i(tx_data), .tx_we_i(tx_we), .tx_o(tx), .tx_busy_o(tx_busy),
    .cts_en_i(cts_en), .cts_i(cts), .rx_en_i(rx_en), .rx_i(rx_line), .rx_read_i(rx_read),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid), .rts_en_i(rts_en), .rts_o(rts),
    .overrun_o(ovr), .frame_err_o(ferr)
  );

  always @(posedge clk or negedge rst_n)
    if (!rst_n) cyc <= 0; else cyc <= cyc + 1;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit is_ovf(input int k);
    if ((k % g_p) != g_p - 1) return 0;
    return (((k + 1) / g_p - 1) % (g_d + 1)) == 0;
  endfunction

  function automatic int dmask();
    return (1 << g_nd) - 1;
  endfunction

  function automatic int n_bits();
    return 2 + g_nd + int'(g_pe) + int'(g_s2);
  endfunction

  function automatic int exp_bit(input int data, input int b);
    if (b == 0) return 0;
    if (b <= g_nd) return (data >> (b - 1)) & 1;
    if (g_pe && b == g_nd + 1) return int'((^(data & dmask())) ^ g_po);
    return 1;
  endfunction

  task automatic wait_cyc(input int n);
    while (cyc < n) @(negedge clk);
  endtask

  task automatic cfg_reset(input int sel, input int d);
    int sh;
    sh = (sel == 0) ? 0 : (sel == 1) ? 1 : (sel == 2) ? 3 : 5;
    clk_sel = 2'(sel); brg_div = 8'(d);
    g_p = 1 << sh; g_d = d; g_t = (d + 1) * g_p;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic set_fmt(input int nd, input bit pe, input bit po, input bit s2);
    data_len = (nd == 7) ? 2'd0 : (nd == 8) ? 2'd1 : 2'd2;
    par_en = pe; par_odd = po; stop2 = s2;
    g_nd = nd; g_pe = pe; g_po = po; g_s2 = s2;
  endtask

  // write at a negedge; checks the start edge against the second overflow
  task automatic tx_write(input int data);
    int kw, k, n;
    kw = cyc;
    tx_data = 9'(data); tx_we = 1;
    @(negedge clk);
    tx_we = 0;
    k = kw + 1; n = 0;
    forever begin
      if (is_ovf(k)) n++;
      if (n == 2) break;
      k++;
    end
    g_start = k;
    wait_cyc(k);     chk("R2 line high before start", int'(tx), 1);
    wait_cyc(k + 1); chk("R2 start bit low", int'(tx), 0);
  endtask

  task automatic check_bits(input int data, input bit r1);
    for (int b = 0; b < n_bits(); b++) begin
      wait_cyc(g_start + 1 + 16 * b * g_t + 8 * g_t);
      chk($sformatf("R3 frame bit %0d", b), int'(tx), exp_bit(data, b));
      if (b == 0 && r1) begin
        wait_cyc(g_start + 16 * g_t);     chk("R1 start bit last clock", int'(tx), 0);
        wait_cyc(g_start + 16 * g_t + 1); chk("R1 first data bit begins", int'(tx), 1);
      end
    end
  endtask

  task automatic wait_idle();
    while (tx_busy) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic rx_get(input int exp, input string tag);
    chk({tag, " valid"}, int'(rx_valid), 1);
    chk({tag, " data"}, int'(rx_data), exp & dmask());
    chk("R6 rts high while unread", int'(rts), int'(rts_en));
    rx_read = 1;
    @(negedge clk);
    rx_read = 0;
    chk("R6 rts low after read", int'(rts), 0);
    chk("R5 valid cleared by read", int'(rx_valid), 0);
  endtask

  task automatic man_frame(input int data, input bit stop_v);
    for (int b = 0; b < 10; b++) begin
      man_rx = (b == 0) ? 1'b0 : (b <= 8) ? 1'((data >> (b - 1)) & 1) : stop_v;
      repeat (16 * g_t) @(negedge clk);
    end
    man_rx = 1;
    repeat (48 * g_t) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int c, k;
    set_fmt(8, 0, 0, 0);
    cfg_reset(0, 0);
    @(negedge clk);
    chk("R3 reset line high", int'(tx), 1);
    chk("R2 reset not busy", int'(tx_busy), 0);
    chk("R5 reset buffer empty", int'(rx_valid), 0);
    chk("R6 reset rts", int'(rts), 0);
    chk("R7 reset overrun", int'(ovr), 0);
    chk("R8 reset frame error", int'(ferr), 0);

    // R1: every prescaler with two reload values
    for (int sel = 0; sel < 4; sel++)
      for (int d = 0; d < 2; d++) begin
        int w;
        cfg_reset(sel, d);
        w = ('h5B ^ (sel << 4) ^ (d << 6)) | 1;
        tx_write(w);
        check_bits(w, 1);
        wait_idle();
        rx_get(w, "R1 loopback");
      end

    // R3/R5: every frame format
    cfg_reset(0, 1);
    for (int nd = 7; nd <= 9; nd++)
      for (int pc = 0; pc < 3; pc++)
        for (int s2 = 0; s2 < 2; s2++) begin
          int w;
          set_fmt(nd, pc != 0, pc == 2, s2 != 0);
          w = ((nd * 37 + pc * 91 + s2 * 29) * 13) & 'h1FF;
          tx_write(w);
          check_bits(w, 0);
          wait_idle();
          rx_get(w, "R5 format");
        end
    set_fmt(8, 0, 0, 0);

    // R2: write while busy is ignored
    tx_write('h3C);
    tx_data = 9'h0C3; tx_we = 1;
    @(negedge clk);
    tx_we = 0;
    wait_idle();
    rx_get('h3C, "R2 first word kept");
    repeat (40 * g_t) @(negedge clk);
    chk("R2 no second frame", int'(tx_busy), 0);
    chk("R2 nothing received", int'(rx_valid), 0);

    // R4: CTS gating
    cts_en = 1; cts = 1;
    tx_data = 9'h05A; tx_we = 1;
    @(negedge clk);
    tx_we = 0;
    repeat (20 * g_t) @(negedge clk);
    chk("R4 held line high", int'(tx), 1);
    chk("R4 held busy", int'(tx_busy), 1);
    cts = 0;
    c = cyc; k = c;
    while (!is_ovf(k)) k++;
    g_start = k;
    wait_cyc(k);     chk("R4 start waits for overflow", int'(tx), 1);
    wait_cyc(k + 1); chk("R4 start after release", int'(tx), 0);
    wait_cyc(g_start + 1 + 48 * g_t);
    cts = 1;
    wait_idle();
    rx_get('h5A, "R4 frame completes under cts");
    cts_en = 0;
    tx_write('h96);
    wait_idle();
    rx_get('h96, "R4 cts ignored when disabled");
    cts = 0;

    // R6: rts disabled
    rts_en = 0;
    tx_write('h18);
    wait_idle();
    chk("R6 rts low when disabled", int'(rts), 0);
    chk("R6 word present", int'(rx_valid), 1);
    rts_en = 1;
    @(negedge clk);
    rx_get('h18, "R6 rts enabled");

    // R7: overrun at the bit before the last stop bit
    tx_write('h11);
    wait_idle();
    tx_write('h22);
    wait_cyc(g_start + 1 + 16 * 8 * g_t + 4 * g_t);
    chk("R7 no overrun before last data bit", int'(ovr), 0);
    wait_cyc(g_start + 1 + 16 * 9 * g_t + 4 * g_t);
    chk("R7 overrun before last stop", int'(ovr), 1);
    wait_idle();
    rx_get('h11, "R7 earlier word kept");
    chk("R7 overrun sticky", int'(ovr), 1);
    rx_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 overrun cleared by rx disable", int'(ovr), 0);
    rx_en = 1;
    tx_write('h33);
    wait_idle();
    tx_write('h44);
    wait_cyc(g_start + 1 + 48 * g_t);
    chk("R7 first word before read", int'(rx_data), 'h33);
    rx_read = 1;
    @(negedge clk);
    rx_read = 0;
    wait_idle();
    chk("R7 no overrun after timely read", int'(ovr), 0);
    rx_get('h44, "R7 new word stored");

    // R8: framing error
    loop_en = 0;
    man_frame('h5C, 1);
    chk("R8 good frame no error", int'(ferr), 0);
    rx_get('h5C, "R5 manual frame");
    man_frame('h6D, 0);
    chk("R8 low stop flagged", int'(ferr), 1);
    rx_get('h6D, "R8 word stored");
    man_frame('h2B, 1);
    chk("R8 error sticky", int'(ferr), 1);
    rx_get('h2B, "R8 later frame");
    rx_en = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 cleared by rx disable", int'(ferr), 0);

    // R9: disabled receiver ignores the line
    loop_en = 1;
    tx_write('h77);
    wait_idle();
    chk("R9 nothing stored while disabled", int'(rx_valid), 0);
    rx_en = 1;

    // R5: runt start pulse dropped
    loop_en = 0;
    man_rx = 0;
    repeat (4 * g_t) @(negedge clk);
    man_rx = 1;
    repeat (40 * 16 * g_t) @(negedge clk);
    chk("R5 runt start dropped", int'(rx_valid), 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule